// File: doc/BRIEF.md
# Register-Mapped SMBus Byte-Data Master

This block is a two-wire bus master that moves single bytes to and from one register of an attached peripheral. Software configures it through a configuration word (enable, a target ID, a clock divider and an option to ignore missing acknowledges). It then writes a command word that carries the peripheral's register number, a data byte and a read flag. The write itself starts the transfer. The same command word reports progress through three flags: write pending, read data valid and error. Every completed transfer sets an interrupt flag, which software clears by writing a one to it.

For a write, the block sends START, the target address with the write bit, the register number, the data byte and STOP. For a read, it sends START, the address with the write bit and the register number. It then sends a repeated START and the address with the read bit, receives one byte, answers it with a NACK and sends STOP. The bus pins are open drain: the block only drives an enable that pulls a line low. The pad releases the line otherwise, and the sensed data line comes back on an input.

The register bus has a two-bit address, a one-cycle write strobe and a read data path that follows the address without delay.

Top module: `smbus_byte_master`

## Requirements
- R1: After reset, the configuration word (address 0), the command word (address 1) and the interrupt word (address 2) all read 0, both line enables are 0 and `irq` is 0.
- R2: The configuration word keeps enable in bit 0, a stored mode flag in bit 1, the target ID in bits 9:2, the divider in bits 18:10, ignore-acknowledge in bit 22 and a stored compatibility flag in bit 23. All of these read back as written, and every other bit reads 0.
- R3: Writing the command word with bit 24 clear, while enabled and idle, sets write-pending (bit 25) and clears read-valid (bit 26) and error (bit 27). The block then sends START, the byte {ID[7:1],0}, the register number (bits 23:16), the data byte (bits 7:0) and STOP. On success, write-pending clears.
- R4: Writing the command word with bit 24 set sends START, {ID[7:1],0}, the register number, a repeated START, {ID[7:1],1}, receives one byte answered by a NACK, and sends STOP. It then sets read-valid and places the byte in bits 7:0.
- R5: When ignore-acknowledge is clear, a missing acknowledge on any transmitted byte ends the transfer with STOP, sets error and clears write-pending.
- R6: When ignore-acknowledge is set, missing acknowledges are ignored and the transfer completes normally. A read from an absent peripheral then returns 0xFF.
- R7: Each completed transfer sets the interrupt flag (address 2 bit 0, mirrored on `irq`). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: Each SCL half period lasts max(divider,1)+1 clock cycles.
- R9: SDA and SCL never change in the same cycle. SDA changes while SCL is high only as START (falling) or STOP (rising).
- R10: A command-word write is ignored while a transfer is running or while enable is clear.
- R11: Write-pending is never set together with read-valid or with error.
- R12: Both line enables are 0 whenever no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 configuration, 1 command/status, 2 interrupt |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt flag |

## Verification
The main function is driven by a table of transfers against a bench peripheral model. The table mixes writes and reads at several register numbers and data values, including 0x00 and 0xFF, so that a swapped, shifted or unsent byte shows up as a wrong readback. Entries with a wrong target ID are run with acknowledge checking both on and off, which separates the error-and-STOP path from the ignore path and shows that a released bus reads as 0xFF. Directed cases cover a peripheral that refuses the data byte, a command write while busy and while disabled, divider values 0, 1 and 5, and START/STOP counts, which confirm the repeated START appears only on reads.

// File: rtl/smbus_pkg.sv
`timescale 1ns/1ps
package smbus_pkg;
  localparam int REG_W   = 32;
  localparam int TID_W   = 8;
  localparam int DIV_W   = 9;
  localparam int CMD_W   = 8;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;

  // configuration word field positions
  localparam int F_EN     = 0;
  localparam int F_MODE   = 1;
  localparam int F_TID_LO = 2;
  localparam int F_DIV_LO = 10;
  localparam int F_IGNACK = 22;
  localparam int F_COMPAT = 23;

  // command/status word field positions
  localparam int F_DAT_LO = 0;
  localparam int F_CMD_LO = 16;
  localparam int F_RD     = 24;
  localparam int F_WPEND  = 25;
  localparam int F_RVALID = 26;
  localparam int F_ERR    = 27;

  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_IRQ = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_A, S_STA_B, S_BIT_L, S_BIT_H,
    S_RS_L, S_STP_L, S_STP_H, S_STP_E
  } eng_st_e;

  typedef enum logic [2:0] {
    K_ADDRW, K_CMD, K_DATA, K_ADDRR, K_RXD
  } byte_kind_e;
endpackage

// File: rtl/smbus_halfclk.sv
`timescale 1ns/1ps
module smbus_halfclk #(
  parameter int DIV_W = smbus_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last;

  // half period of div+1 clocks, never shorter than two
  assign last = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt_q == last);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smbus_engine.sv
`timescale 1ns/1ps
module smbus_engine
  import smbus_pkg::*;
#(
  parameter int DIV_W  = smbus_pkg::DIV_W,
  parameter int BYTE_W = smbus_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_rd,
  input  logic [BYTE_W-2:0] tgt_addr,
  input  logic [BYTE_W-1:0] reg_num,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              ign_ack,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic              done_rd,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BITC_W = $clog2(BYTE_W + 1);
  localparam logic [BITC_W-1:0] ACK_SLOT = BITC_W'(BYTE_W);

  eng_st_e            st_q, st_d;
  byte_kind_e         kind_q, kind_d;
  logic [BITC_W-1:0]  bitn_q, bitn_d;
  logic [BYTE_W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [BYTE_W-1:0]  cmd_q, cmd_d, wb_q, wb_d;
  logic [BYTE_W-2:0]  tid_q, tid_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               rd_q, rd_d, err_q, err_d, ign_q, ign_d;
  logic               scl_q, scl_d, sda_q, sda_d;
  logic               tick, want_rel, nacked;

  smbus_halfclk #(.DIV_W(DIV_W)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q != S_IDLE),
    .div  (div_q),
    .tick (tick)
  );

  assign want_rel = (kind_q == K_RXD) || (bitn_q == ACK_SLOT) || tx_q[BYTE_W-1];
  assign nacked   = (kind_q != K_RXD) && sda_in && !ign_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;   kind_d = kind_q; bitn_d = bitn_q;
    tx_d   = tx_q;   rx_d   = rx_q;   cmd_d  = cmd_q;
    wb_d   = wb_q;   tid_d  = tid_q;  div_d  = div_q;
    rd_d   = rd_q;   err_d  = err_q;  ign_d  = ign_q;
    done   = 1'b0;
    unique case (st_q)
      S_IDLE: if (launch) begin
        st_d   = S_STA_A;
        kind_d = K_ADDRW;
        bitn_d = '0;
        tx_d   = {tgt_addr, 1'b0};
        tid_d  = tgt_addr;
        cmd_d  = reg_num;
        wb_d   = wr_byte;
        div_d  = div;
        ign_d  = ign_ack;
        rd_d   = launch_rd;
        err_d  = 1'b0;
      end
      S_STA_A: if (tick) st_d = S_STA_B;
      S_STA_B: if (tick) st_d = S_BIT_L;
      S_BIT_L: if (tick) st_d = S_BIT_H;
      S_BIT_H: if (tick) begin
        if (bitn_q != ACK_SLOT) begin
          if (kind_q == K_RXD) rx_d = {rx_q[BYTE_W-2:0], sda_in};
          tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
          bitn_d = bitn_q + BITC_W'(1);
          st_d   = S_BIT_L;
        end else begin
          bitn_d = '0;
          if (nacked) begin
            err_d = 1'b1;
            st_d  = S_STP_L;
          end else begin
            unique case (kind_q)
              K_ADDRW: begin kind_d = K_CMD; tx_d = cmd_q; st_d = S_BIT_L; end
              K_CMD: begin
                if (rd_q) begin kind_d = K_ADDRR; tx_d = {tid_q, 1'b1}; st_d = S_RS_L; end
                else      begin kind_d = K_DATA;  tx_d = wb_q;          st_d = S_BIT_L; end
              end
              K_ADDRR: begin kind_d = K_RXD; st_d = S_BIT_L; end
              default: st_d = S_STP_L;
            endcase
          end
        end
      end
      S_RS_L:  if (tick) st_d = S_STA_A;
      S_STP_L: if (tick) st_d = S_STP_H;
      S_STP_H: if (tick) st_d = S_STP_E;
      S_STP_E: if (tick) begin st_d = S_IDLE; done = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  // line drivers: SCL follows the state a cycle later; SDA moves in a
  // low phase only once SCL is already seen low
  always_comb begin
    scl_d = (st_q == S_BIT_L) || (st_q == S_RS_L) || (st_q == S_STP_L);
    unique case (st_q)
      S_STA_B: sda_d = 1'b1;
      S_BIT_L: sda_d = scl_q ? !want_rel : sda_q;
      S_RS_L:  sda_d = scl_q ? 1'b0 : sda_q;
      S_STP_L: sda_d = scl_q ? 1'b1 : sda_q;
      S_BIT_H, S_STP_H: sda_d = sda_q;
      default: sda_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kind_q <= K_ADDRW; bitn_q <= '0;
      tx_q <= '0;      rx_q   <= '0;      cmd_q  <= '0;
      wb_q <= '0;      tid_q  <= '0;      div_q  <= '0;
      rd_q <= 1'b0;    err_q  <= 1'b0;    ign_q  <= 1'b0;
      scl_q <= 1'b0;   sda_q  <= 1'b0;
    end else begin
      st_q <= st_d;    kind_q <= kind_d;  bitn_q <= bitn_d;
      tx_q <= tx_d;    rx_q   <= rx_d;    cmd_q  <= cmd_d;
      wb_q <= wb_d;    tid_q  <= tid_d;   div_q  <= div_d;
      rd_q <= rd_d;    err_q  <= err_d;   ign_q  <= ign_d;
      scl_q <= scl_d;  sda_q  <= sda_d;
    end
  end

  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign busy     = (st_q != S_IDLE);
  assign done_err = err_q;
  assign done_rd  = rd_q;
  assign rx_byte  = rx_q;
endmodule

// File: rtl/smbus_regs.sv
`timescale 1ns/1ps
module smbus_regs
  import smbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_rd,
  input  logic [BYTE_W-1:0] eng_rx,
  output logic              launch,
  output logic              launch_rd,
  output logic [TID_W-1:0]  cfg_tid,
  output logic [DIV_W-1:0]  cfg_div,
  output logic              cfg_ign,
  output logic [CMD_W-1:0]  launch_cmd,
  output logic [BYTE_W-1:0] launch_byte,
  output logic              irq
);
  logic en_q, en_d, mode_q, mode_d, ign_q, ign_d, compat_q, compat_d;
  logic [TID_W-1:0]  tid_q, tid_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic rd_q, rd_d, wpend_q, wpend_d, rvalid_q, rvalid_d, err_q, err_d;
  logic irq_q, irq_d;
  logic wr_cfg, wr_cmd, wr_irq;
  logic unused_wbits;

  assign wr_cfg = bus_wr && (bus_addr == A_CFG);
  assign wr_cmd = bus_wr && (bus_addr == A_CMD);
  assign wr_irq = bus_wr && (bus_addr == A_IRQ);
  assign launch = wr_cmd && en_q && !eng_busy;

  assign launch_rd   = bus_wdata[F_RD];
  assign launch_cmd  = bus_wdata[F_CMD_LO +: CMD_W];
  assign launch_byte = bus_wdata[F_DAT_LO +: BYTE_W];
  assign cfg_tid     = tid_q;
  assign cfg_div     = div_q;
  assign cfg_ign     = ign_q;
  assign irq         = irq_q;
  assign unused_wbits = ^{bus_wdata[REG_W-1:F_ERR+1], bus_wdata[F_IGNACK-1:F_DIV_LO+DIV_W]};

  always_comb begin
    en_d = en_q; mode_d = mode_q; ign_d = ign_q; compat_d = compat_q;
    tid_d = tid_q; div_d = div_q; cmd_d = cmd_q; dat_d = dat_q;
    rd_d = rd_q; wpend_d = wpend_q; rvalid_d = rvalid_q; err_d = err_q;
    irq_d = irq_q;
    if (wr_cfg) begin
      en_d     = bus_wdata[F_EN];
      mode_d   = bus_wdata[F_MODE];
      tid_d    = bus_wdata[F_TID_LO +: TID_W];
      div_d    = bus_wdata[F_DIV_LO +: DIV_W];
      ign_d    = bus_wdata[F_IGNACK];
      compat_d = bus_wdata[F_COMPAT];
    end
    if (launch) begin
      cmd_d    = bus_wdata[F_CMD_LO +: CMD_W];
      dat_d    = bus_wdata[F_DAT_LO +: DATA_W];
      rd_d     = bus_wdata[F_RD];
      wpend_d  = !bus_wdata[F_RD];
      rvalid_d = 1'b0;
      err_d    = 1'b0;
    end
    if (eng_done) begin
      irq_d = 1'b1;
      if (eng_err) begin
        err_d   = 1'b1;
        wpend_d = 1'b0;
      end else if (eng_rd) begin
        rvalid_d          = 1'b1;
        dat_d[BYTE_W-1:0] = eng_rx;
      end else begin
        wpend_d = 1'b0;
      end
    end else if (wr_irq && bus_wdata[0]) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; ign_q <= 1'b0; compat_q <= 1'b0;
      tid_q <= '0; div_q <= '0; cmd_q <= '0; dat_q <= '0;
      rd_q <= 1'b0; wpend_q <= 1'b0; rvalid_q <= 1'b0; err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q <= en_d; mode_q <= mode_d; ign_q <= ign_d; compat_q <= compat_d;
      tid_q <= tid_d; div_q <= div_d; cmd_q <= cmd_d; dat_q <= dat_d;
      rd_q <= rd_d; wpend_q <= wpend_d; rvalid_q <= rvalid_d; err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CFG: begin
        bus_rdata[F_EN]                  = en_q;
        bus_rdata[F_MODE]                = mode_q;
        bus_rdata[F_TID_LO +: TID_W]     = tid_q;
        bus_rdata[F_DIV_LO +: DIV_W]     = div_q;
        bus_rdata[F_IGNACK]              = ign_q;
        bus_rdata[F_COMPAT]              = compat_q;
      end
      A_CMD: begin
        bus_rdata[F_DAT_LO +: DATA_W]    = dat_q;
        bus_rdata[F_CMD_LO +: CMD_W]     = cmd_q;
        bus_rdata[F_RD]                  = rd_q;
        bus_rdata[F_WPEND]               = wpend_q;
        bus_rdata[F_RVALID]              = rvalid_q;
        bus_rdata[F_ERR]                 = err_q;
      end
      A_IRQ:   bus_rdata[0]              = irq_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smbus_byte_master.sv
`timescale 1ns/1ps
module smbus_byte_master
  import smbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             irq
);
  logic              eng_busy, eng_done, eng_err, eng_rd;
  logic [BYTE_W-1:0] eng_rx;
  logic              launch, launch_rd, cfg_ign;
  logic [TID_W-1:0]  cfg_tid;
  logic [DIV_W-1:0]  cfg_div;
  logic [CMD_W-1:0]  launch_cmd;
  logic [BYTE_W-1:0] launch_byte;
  logic              unused_tid0;

  assign unused_tid0 = cfg_tid[0];

  smbus_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .eng_rd     (eng_rd),
    .eng_rx     (eng_rx),
    .launch     (launch),
    .launch_rd  (launch_rd),
    .cfg_tid    (cfg_tid),
    .cfg_div    (cfg_div),
    .cfg_ign    (cfg_ign),
    .launch_cmd (launch_cmd),
    .launch_byte(launch_byte),
    .irq        (irq)
  );

  smbus_engine #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .launch_rd(launch_rd),
    .tgt_addr (cfg_tid[TID_W-1:1]),
    .reg_num  (launch_cmd),
    .wr_byte  (launch_byte),
    .div      (cfg_div),
    .ign_ack  (cfg_ign),
    .sda_in   (sda_in),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (eng_busy),
    .done     (eng_done),
    .done_err (eng_err),
    .done_rd  (eng_rd),
    .rx_byte  (eng_rx)
  );
endmodule

// File: rtl/smbus_byte_master_chk.sv
`timescale 1ns/1ps
module smbus_byte_master_chk
  import smbus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [REG_W-1:0] bus_rdata,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             irq,
  input logic             busy
);
  // R9
  line_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $stable(scl_oe));

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!scl_oe && !sda_oe));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy) && !busy));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CMD) |-> !(bus_rdata[F_WPEND] && (bus_rdata[F_RVALID] || bus_rdata[F_ERR])));

  // R3
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && (bus_addr == A_CMD)));
endmodule

bind smbus_byte_master smbus_byte_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .irq      (irq),
  .busy     (eng_busy)
);

// File: tb/test_smbus_byte_master.sv
`timescale 1ns/1ps
module test_smbus_byte_master;
  import smbus_pkg::*;

  logic clk, rst_n, bus_wr, sda_in, scl_oe, sda_oe, irq;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_chk = 0, n_fail = 0;

  smbus_byte_master i_smbus_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- bench peripheral on the open-drain bus ----------------
  localparam logic [6:0] SLV_ADR = 7'h21;
  localparam logic [7:0] TID_OK  = 8'h42;   // bits 7:1 = 0x21
  localparam logic [7:0] TID_BAD = 8'h5A;   // bits 7:1 = 0x2D, nobody there
  logic slv_pull, scl_line, sda_line, s_act, s_ack, s_tx, nack_data;
  logic [7:0] smem [256];
  logic [7:0] s_sh, s_ptr, s_txb;
  int s_bit, s_idx, n_start, n_stop;

  assign scl_line = ~scl_oe;
  assign sda_line = ~sda_oe & ~slv_pull;
  assign sda_in   = sda_line;

  initial begin
    slv_pull = 0; s_act = 0; s_ack = 0; s_tx = 0; nack_data = 0;
    s_bit = 0; s_idx = 0; s_ptr = 0; s_sh = 0; s_txb = 0; n_start = 0; n_stop = 0;
    for (int i = 0; i < 256; i++) smem[i] = 8'(i) ^ 8'hC3;
  end

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    n_start++; s_act = 1; s_bit = 0; s_idx = 0; s_ack = 0; s_tx = 0; slv_pull = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    n_stop++; s_act = 0; slv_pull = 0;
  end
  always @(posedge scl_line) if (s_act && !s_ack && s_bit < 8) begin
    s_sh = {s_sh[6:0], sda_line}; s_bit++;
  end
  always @(negedge scl_line) if (s_act) begin
    if (s_ack) begin
      s_ack = 0; s_bit = 0; slv_pull = s_tx ? ~s_txb[7] : 1'b0;
    end else if (s_tx) begin
      if (s_bit < 8) slv_pull = ~s_txb[7 - s_bit];
      else begin slv_pull = 0; s_act = 0; end
    end else if (s_bit == 8) begin
      logic ack;
      ack = 1;
      if (s_idx == 0) begin
        if (s_sh[7:1] != SLV_ADR) ack = 0;
        else if (s_sh[0]) begin s_tx = 1; s_txb = smem[s_ptr]; end
      end else if (s_idx == 1) s_ptr = s_sh;
      else begin smem[s_ptr] = s_sh; ack = !nack_data; end
      s_idx++;
      if (ack) begin s_ack = 1; slv_pull = 1; end
      else s_act = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_irq(output logic ok);
    ok = 0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk); if (irq) ok = 1;
    end
  endtask

  function automatic logic [31:0] cfg(input logic [7:0] tid, input logic [8:0] dv, input logic ig);
    return 32'(1) | (32'(tid) << F_TID_LO) | (32'(dv) << F_DIV_LO) | (32'(ig) << F_IGNACK);
  endfunction

  function automatic logic [31:0] cmdw(input logic r, input logic [7:0] c, input logic [7:0] d);
    return (32'(r) << F_RD) | (32'(c) << F_CMD_LO) | 32'(d);
  endfunction

  // ---------------- transfer table ----------------
  typedef struct packed {
    logic rdop; logic ign; logic [7:0] tid; logic [7:0] cmd;
    logic [7:0] wd; logic [2:0] st; logic [7:0] eb;
  } vec_t;
  // st = {err, rvalid, wpend}
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, TID_OK,  8'h10, 8'hA5, 3'b000, 8'h00},
    '{1'b0, 1'b0, TID_OK,  8'h11, 8'h3C, 3'b000, 8'h00},
    '{1'b1, 1'b0, TID_OK,  8'h10, 8'h00, 3'b010, 8'hA5},
    '{1'b1, 1'b0, TID_OK,  8'h11, 8'h00, 3'b010, 8'h3C},
    '{1'b0, 1'b0, TID_BAD, 8'h12, 8'h55, 3'b100, 8'h00},
    '{1'b1, 1'b0, TID_BAD, 8'h12, 8'h00, 3'b100, 8'h00},
    '{1'b0, 1'b1, TID_BAD, 8'h13, 8'h66, 3'b000, 8'h00},
    '{1'b0, 1'b0, TID_OK,  8'hFF, 8'h00, 3'b000, 8'h00},
    '{1'b1, 1'b0, TID_OK,  8'hFF, 8'h00, 3'b010, 8'h00},
    '{1'b1, 1'b1, TID_BAD, 8'h14, 8'h00, 3'b010, 8'hFF}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic ok;
    time t1, t2;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_CFG, v); chk("R1 cfg word", v, 0);
    rd(A_CMD, v); chk("R1 cmd word", v, 0);
    rd(A_IRQ, v); chk("R1 irq word", v, 0);
    chk("R1 irq/lines", {29'd0, irq, scl_oe, sda_oe}, 0);

    // R10 command write while disabled is ignored
    wr(A_CMD, cmdw(0, 8'h30, 8'h44));
    repeat (60) @(negedge clk);
    rd(A_CMD, v); chk("R10 disabled write", v, 0);
    chk("R10 disabled no irq", {31'd0, irq}, 0);
    chk("R12 lines idle", {30'd0, scl_oe, sda_oe}, 0);

    // R2 configuration readback
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v); chk("R2 cfg all ones", v, 32'h00C7_FFFF);
    wr(A_CFG, 32'h0080_0002);
    rd(A_CFG, v); chk("R2 mode/compat only", v, 32'h0080_0002);

    // R3 R4 R5 R6 R7 table of transfers
    foreach (VEC[i]) begin
      wr(A_CFG, cfg(VEC[i].tid, 9'd2, VEC[i].ign));
      n_start = 0; n_stop = 0;
      wr(A_CMD, cmdw(VEC[i].rdop, VEC[i].cmd, VEC[i].wd));
      rd(A_CMD, v);
      chk($sformatf("R3 launch flags vec %0d", i), {29'd0, v[F_ERR], v[F_RVALID], v[F_WPEND]},
          {29'd0, 2'b00, !VEC[i].rdop});
      wait_irq(ok);
      chk($sformatf("R7 irq vec %0d", i), {31'd0, ok}, 1);
      rd(A_CMD, v);
      chk($sformatf("R3/R4/R5/R6 status vec %0d", i), v,
          {4'd0, VEC[i].st, VEC[i].rdop, VEC[i].cmd, 8'h00, VEC[i].rdop ? VEC[i].eb : VEC[i].wd});
      repeat (4) @(negedge clk);
      chk($sformatf("R9 start count vec %0d", i), n_start,
          (VEC[i].rdop && VEC[i].st != 3'b100) ? 2 : 1);
      chk($sformatf("R5 stop count vec %0d", i), n_stop, 1);
      wr(A_IRQ, 32'h1);
    end

    // R10 command write while busy is ignored
    wr(A_CFG, cfg(TID_OK, 9'd2, 0));
    wr(A_CMD, cmdw(0, 8'h20, 8'h77));
    repeat (20) @(negedge clk);
    wr(A_CMD, cmdw(0, 8'h21, 8'h99));
    wait_irq(ok);
    rd(A_CMD, v); chk("R10 busy write kept first", v, cmdw(0, 8'h20, 8'h77));
    wr(A_IRQ, 32'h1);
    wr(A_CMD, cmdw(1, 8'h21, 8'h00));
    wait_irq(ok);
    rd(A_CMD, v); chk("R10 second write never sent", v[7:0], 8'h21 ^ 8'hC3);

    // R7 write-one-to-clear
    wr(A_IRQ, 32'h0);
    rd(A_IRQ, v); chk("R7 write 0 keeps irq", v, 1);
    wr(A_IRQ, 32'h1);
    rd(A_IRQ, v); chk("R7 write 1 clears irq", v, 0);

    // R5 peripheral refuses the data byte
    nack_data = 1;
    n_stop = 0;
    wr(A_CMD, cmdw(0, 8'h22, 8'h5E));
    wait_irq(ok);
    rd(A_CMD, v); chk("R5 data nack error", v[F_ERR+:3] , 3'b001);
    repeat (4) @(negedge clk);
    chk("R5 data nack stop", n_stop, 1);
    chk("R12 lines released after error", {30'd0, scl_oe, sda_oe}, 0);
    nack_data = 0;
    wr(A_IRQ, 32'h1);

    // R8 half period for several dividers
    foreach (VEC[k]) if (k < 3) begin
      logic [8:0] dv;
      int exp_hp;
      dv = (k == 0) ? 9'd5 : (k == 1) ? 9'd0 : 9'd1;
      exp_hp = ((dv == 0) ? 1 : int'(dv)) + 1;
      wr(A_CFG, cfg(TID_OK, dv, 0));
      wr(A_CMD, cmdw(0, 8'h40, 8'h01));
      @(negedge scl_line); t1 = $time;
      @(negedge scl_line); t2 = $time;
      chk($sformatf("R8 period div %0d", dv), 32'((t2 - t1) / 10), 32'(2 * exp_hp));
      wait_irq(ok);
      wr(A_IRQ, 32'h1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule